// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a 16-bit parallel NOR flash bus and turns one request into a complete, self-timed write operation. A request carries an operation code, a target word address and, for a word program, the data word. Once the block accepts a request, it emits the unlock and command write cycles that the flash expects. It then reads the target location over and over until the toggling status bit (bit 6 of the data bus) settles. Finally it reports success or a timeout on a one-cycle done pulse.

Strobe timing is expressed in clock cycles. For a write, the block spends a setup time with the address driven, holds write-enable low for the pulse time, and keeps data and address stable for a hold time after write-enable rises. For a read, output-enable stays low for the read time and is followed by one idle cycle. End of operation is declared only after a settled pair of reads is confirmed by further reads, so a sample taken at the instant the flash finishes cannot produce a false result. Each kind of operation has its own timeout, set in microseconds together with the clock rate. A request that runs past its timeout ends with a single reset command and an error flag.

Top module: `flash_pe_ctrl`

## Requirements
- R1: Out of reset, chip-enable, write-enable and output-enable are all high, the data bus is not driven (`flashDoe`=0), `doneValid` is 0 and `reqReady` is 1.
- R2: Operation code 0 (word program) issues exactly four write cycles, as address/data: 0x555/0x00AA, 0x2AA/0x0055, 0x555/0x00A0, then target address/request data.
- R3: Operation codes 1 (sector erase), 2 (block erase) and 3 (chip erase) issue six write cycles: 0x555/0x00AA, 0x2AA/0x0055, 0x555/0x0080, 0x555/0x00AA, 0x2AA/0x0055, then target/0x0050, target/0x0030 or 0x555/0x0010 respectively. Command bytes sit in data bits 7:0 with bits 15:8 zero.
- R4: Each write cycle holds chip-enable low and drives the bus. Write-enable falls after SETUP_CYC cycles and stays low for exactly PULSE_CYC cycles, and address and data do not change while it is low. Data stays driven for HOLD_CYC cycles after it rises.
- R5: Each status read drives the request's target address with chip-enable low, output-enable low for READ_CYC cycles, write-enable high and the bus released. One cycle with output-enable high follows each read.
- R6: Success (`doneErr`=0) is reported after the first read whose bit 6 equals that of the three reads before it. This is one settled pair plus CONFIRM_RD (default 2) confirming reads. A run of equal reads shorter than this does not end the operation.
- R7: With W = SETUP_CYC+PULSE_CYC+HOLD_CYC and R = READ_CYC+1, `doneValid` rises k·W + n·R cycles after the accepting clock edge on success (k writes, n reads). On timeout it rises W cycles later than that.
- R8: The poll timer starts at the first read and advances one per cycle. At the end of each read that does not confirm completion, the operation times out if the timer is at least the limit: PROG_TMO_US·CLK_MHZ cycles for code 0, ERASE_TMO_US·CLK_MHZ for codes 1 and 2, CHIP_TMO_US·CLK_MHZ for code 3.
- R9: On timeout, exactly one extra write cycle of 0x00F0 to address 0 is issued, then `doneValid` is raised with `doneErr`=1.
- R10: `reqReady` is high only while idle. A request presented during an operation causes no write or read and is not accepted later once it has been withdrawn.
- R11: `doneValid` is a single-cycle pulse, and `doneErr` is high only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| reqAddr | input | ADDR_W | Target word address |
| reqData | input | DATA_W | Word to program |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Operation timed out |
| flashCeN | output | 1 | Chip enable, active low |
| flashWeN | output | 1 | Write enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashAddr | output | ADDR_W | Flash address |
| flashDout | output | DATA_W | Data to flash |
| flashDoe | output | 1 | Drive enable for flashDout |
| flashDin | input | DATA_W | Data from flash |

## Verification
Each result's due cycle follows from the request: the done pulse arrives exactly k·W + n·R cycles after the accepting edge, plus W more when the operation times out. Here n comes from the flash model's scripted bit-6 sequence and the per-operation timeout. The bench computes that figure and the expected read and write counts before each request. It then counts clock edges from acceptance, samples outputs on the falling clock edge, and requires the pulse on exactly that edge and its absence one cycle later. Write cycles are captured by the flash model on each write-enable rise. Pulse width is measured in time between the write-enable fall and rise, and every status-read address is checked at the output-enable fall.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_SECTOR  = 2'd1,
    OP_BLOCK   = 2'd2,
    OP_CHIP    = 2'd3
  } fpcOp_e;

  // control -> datapath
  typedef struct packed {
    logic       load;
    logic       busWrite;
    logic       busRead;
    logic       weLow;
    logic       oeLow;
    logic [2:0] wrIdx;
    logic       abortWr;
    logic       sample;
    logic       evalRead;
    logic       pollRun;
  } fpcStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic isProgram;
    logic confirmed;
    logic expired;
  } fpcStatus_t;

  localparam int PROG_STEPS  = 4;
  localparam int ERASE_STEPS = 6;

  localparam logic [7:0]  CMD_KEY_A    = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_PROG     = 8'hA0;
  localparam logic [7:0]  CMD_ERASE    = 8'h80;
  localparam logic [7:0]  CMD_SECT     = 8'h50;
  localparam logic [7:0]  CMD_BLK      = 8'h30;
  localparam logic [7:0]  CMD_CHIP     = 8'h10;
  localparam logic [7:0]  CMD_READMODE = 8'hF0;
  localparam logic [10:0] KEY_ADDR_A   = 11'h555;
  localparam logic [10:0] KEY_ADDR_B   = 11'h2AA;

endpackage

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       doneValid,
  output logic       doneErr,
  input  fpcStatus_t stat,
  output fpcStrobe_t strb
);

  localparam int WR_SPAN = SETUP_CYC + PULSE_CYC + HOLD_CYC;
  localparam int RD_SPAN = READ_CYC + 1;
  localparam int MAX_SPAN = (WR_SPAN > RD_SPAN) ? WR_SPAN : RD_SPAN;
  localparam int CYC_W = $clog2(MAX_SPAN + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_POLL, S_ABORT, S_DONE
  } state_e;

  state_e           state, stateNxt;
  logic [CYC_W-1:0] cyc, cycNxt;
  logic [2:0]       idx, idxNxt;
  logic             errFlag, errNxt;
  logic             weWindow;
  logic             wrLast, rdGap;
  logic [2:0]       lastIdx;

  assign weWindow = (cyc >= CYC_W'(SETUP_CYC)) && (cyc < CYC_W'(SETUP_CYC + PULSE_CYC));
  assign wrLast   = (cyc == CYC_W'(WR_SPAN - 1));
  assign rdGap    = (cyc == CYC_W'(READ_CYC));
  assign lastIdx  = stat.isProgram ? 3'(PROG_STEPS - 1) : 3'(ERASE_STEPS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cyc     <= '0;
      idx     <= '0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNxt;
      cyc     <= cycNxt;
      idx     <= idxNxt;
      errFlag <= errNxt;
    end
  end

  always_comb begin
    stateNxt  = state;
    cycNxt    = cyc;
    idxNxt    = idx;
    errNxt    = errFlag;
    strb      = '0;
    reqReady  = 1'b0;
    doneValid = 1'b0;
    doneErr   = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.load = 1'b1;
          stateNxt  = S_WRITE;
          cycNxt    = '0;
          idxNxt    = '0;
          errNxt    = 1'b0;
        end
      end
      S_WRITE: begin
        strb.busWrite = 1'b1;
        strb.weLow    = weWindow;
        strb.wrIdx    = idx;
        if (wrLast) begin
          cycNxt = '0;
          if (idx == lastIdx) stateNxt = S_POLL;
          else                idxNxt   = idx + 3'd1;
        end else begin
          cycNxt = cyc + 1'b1;
        end
      end
      S_POLL: begin
        strb.busRead = 1'b1;
        strb.pollRun = 1'b1;
        strb.oeLow   = (cyc < CYC_W'(READ_CYC));
        strb.sample  = (cyc == CYC_W'(READ_CYC - 1));
        if (rdGap) begin
          strb.evalRead = 1'b1;
          cycNxt        = '0;
          if (stat.confirmed)    stateNxt = S_DONE;
          else if (stat.expired) stateNxt = S_ABORT;
        end else begin
          cycNxt = cyc + 1'b1;
        end
      end
      S_ABORT: begin
        strb.busWrite = 1'b1;
        strb.abortWr  = 1'b1;
        strb.weLow    = weWindow;
        if (wrLast) begin
          cycNxt   = '0;
          errNxt   = 1'b1;
          stateNxt = S_DONE;
        end else begin
          cycNxt = cyc + 1'b1;
        end
      end
      S_DONE: begin
        doneValid = 1'b1;
        doneErr   = errFlag;
        stateNxt  = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/fpc_dp.sv
module fpc_dp
  import fpc_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 16,
  parameter int TOGGLE_BIT    = 6,
  parameter int CONFIRM_RD    = 2,
  parameter int PROG_TMO_CYC  = 4000,
  parameter int ERASE_TMO_CYC = 8000000,
  parameter int CHIP_TMO_CYC  = 16000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpcStrobe_t        strb,
  output fpcStatus_t        stat,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashDoe,
  input  logic [DATA_W-1:0] flashDin
);

  localparam int MAX_A = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
  localparam int MAX_TMO = (MAX_A > CHIP_TMO_CYC) ? MAX_A : CHIP_TMO_CYC;
  localparam int TMR_W = $clog2(MAX_TMO + 2);
  localparam int STB_W = $clog2(CONFIRM_RD + 2);
  localparam logic [ADDR_W-1:0] ADDR_KA = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_KB = ADDR_W'(KEY_ADDR_B);

  fpcOp_e            opQ;
  logic [ADDR_W-1:0] tgtAddr;
  logic [DATA_W-1:0] tgtData;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;
  logic              rdBit, prevBit, firstRd, match;
  logic [STB_W-1:0]  stableCnt;
  logic [TMR_W-1:0]  timer, limit;
  logic              unusedDin;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ     <= OP_PROGRAM;
      tgtAddr <= '0;
      tgtData <= '0;
    end else if (strb.load) begin
      opQ     <= fpcOp_e'(reqOp);
      tgtAddr <= reqAddr;
      tgtData <= reqData;
    end
  end

  // command cycle table
  always_comb begin
    cmdAddr = '0;
    cmdData = '0;
    if (strb.abortWr) begin
      cmdData = DATA_W'(CMD_READMODE);
    end else begin
      unique case (strb.wrIdx)
        3'd0: begin cmdAddr = ADDR_KA; cmdData = DATA_W'(CMD_KEY_A); end
        3'd1: begin cmdAddr = ADDR_KB; cmdData = DATA_W'(CMD_KEY_B); end
        3'd2: begin
          cmdAddr = ADDR_KA;
          cmdData = (opQ == OP_PROGRAM) ? DATA_W'(CMD_PROG) : DATA_W'(CMD_ERASE);
        end
        3'd3: begin
          if (opQ == OP_PROGRAM) begin
            cmdAddr = tgtAddr;
            cmdData = tgtData;
          end else begin
            cmdAddr = ADDR_KA;
            cmdData = DATA_W'(CMD_KEY_A);
          end
        end
        3'd4: begin cmdAddr = ADDR_KB; cmdData = DATA_W'(CMD_KEY_B); end
        default: begin
          unique case (opQ)
            OP_SECTOR: begin cmdAddr = tgtAddr; cmdData = DATA_W'(CMD_SECT); end
            OP_BLOCK:  begin cmdAddr = tgtAddr; cmdData = DATA_W'(CMD_BLK);  end
            default:   begin cmdAddr = ADDR_KA; cmdData = DATA_W'(CMD_CHIP); end
          endcase
        end
      endcase
    end
  end

  // pin drive
  assign flashCeN  = !(strb.busWrite || strb.busRead);
  assign flashWeN  = !strb.weLow;
  assign flashOeN  = !strb.oeLow;
  assign flashDoe  = strb.busWrite;
  assign flashAddr = strb.busWrite ? cmdAddr : tgtAddr;
  assign flashDout = strb.busWrite ? cmdData : '0;
  assign unusedDin = ^flashDin;

  // toggle tracking
  assign match = !firstRd && (rdBit == prevBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBit     <= 1'b0;
      prevBit   <= 1'b0;
      firstRd   <= 1'b1;
      stableCnt <= '0;
    end else if (strb.load) begin
      rdBit     <= 1'b0;
      prevBit   <= 1'b0;
      firstRd   <= 1'b1;
      stableCnt <= '0;
    end else begin
      if (strb.sample) rdBit <= flashDin[TOGGLE_BIT];
      if (strb.evalRead) begin
        prevBit   <= rdBit;
        firstRd   <= 1'b0;
        stableCnt <= match ? stableCnt + 1'b1 : '0;
      end
    end
  end

  // poll timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        timer <= '0;
    else if (strb.load)               timer <= '0;
    else if (strb.pollRun && !(&timer)) timer <= timer + 1'b1;
  end

  always_comb begin
    unique case (opQ)
      OP_PROGRAM: limit = TMR_W'(PROG_TMO_CYC);
      OP_CHIP:    limit = TMR_W'(CHIP_TMO_CYC);
      default:    limit = TMR_W'(ERASE_TMO_CYC);
    endcase
  end

  assign stat.isProgram = (opQ == OP_PROGRAM);
  assign stat.confirmed = match && (stableCnt == STB_W'(CONFIRM_RD));
  assign stat.expired   = (timer >= limit);

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int DATA_W       = 16,
  parameter int SETUP_CYC    = 1,
  parameter int PULSE_CYC    = 2,
  parameter int HOLD_CYC     = 1,
  parameter int READ_CYC     = 2,
  parameter int CONFIRM_RD   = 2,
  parameter int CLK_MHZ      = 250,
  parameter int PROG_TMO_US  = 16,
  parameter int ERASE_TMO_US = 32000,
  parameter int CHIP_TMO_US  = 64000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              doneValid,
  output logic              doneErr,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashDoe,
  input  logic [DATA_W-1:0] flashDin
);

  localparam int PROG_TMO_CYC  = PROG_TMO_US * CLK_MHZ;
  localparam int ERASE_TMO_CYC = ERASE_TMO_US * CLK_MHZ;
  localparam int CHIP_TMO_CYC  = CHIP_TMO_US * CLK_MHZ;

  fpcStrobe_t strb;
  fpcStatus_t stat;

  fpc_seq #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC),   .READ_CYC(READ_CYC)
  ) u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .doneValid(doneValid), .doneErr(doneErr), .stat(stat), .strb(strb)
  );

  fpc_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOGGLE_BIT(6), .CONFIRM_RD(CONFIRM_RD),
    .PROG_TMO_CYC(PROG_TMO_CYC), .ERASE_TMO_CYC(ERASE_TMO_CYC),
    .CHIP_TMO_CYC(CHIP_TMO_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN),
    .flashAddr(flashAddr), .flashDout(flashDout), .flashDoe(flashDoe),
    .flashDin(flashDin)
  );

endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              doneValid,
  input logic              doneErr,
  input logic              flashCeN,
  input logic              flashWeN,
  input logic              flashOeN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [DATA_W-1:0] flashDout,
  input logic              flashDoe
);

  logic inOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      inOp <= 1'b0;
    else if (reqValid && reqReady)  inOp <= 1'b1;
    else if (doneValid)             inOp <= 1'b0;
  end

  // R4: write strobe only inside a selected, driven cycle
  a_r4_we_framed: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> (!flashCeN && flashDoe && flashOeN));

  // R4: address and data steady while write-enable is low
  a_r4_we_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashDout)));

  // R5: reads release the bus and keep write-enable high
  a_r5_read_framed: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> (!flashCeN && flashWeN && !flashDoe));

  // R10: no acceptance while an operation is running
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    inOp |-> !reqReady);

  // R11: done is a single pulse that closes an accepted operation
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r11_done_in_op: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> inOp);

  a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    doneErr |-> doneValid);

endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .doneValid(doneValid), .doneErr(doneErr), .flashCeN(flashCeN),
  .flashWeN(flashWeN), .flashOeN(flashOeN), .flashAddr(flashAddr),
  .flashDout(flashDout), .flashDoe(flashDoe)
);

// File: tb/flash_pe_ctrl_test.sv
`timescale 1ns/1ps
module flash_pe_ctrl_test;

  localparam int AW = 22;
  localparam int PUL = 2;
  localparam int WSPAN = 4;   // setup 1 + pulse 2 + hold 1
  localparam int RSPAN = 3;   // read 2 + gap 1
  localparam int PT = 60, ET = 120, CT = 240;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [1:0]    reqOp;
  logic [AW-1:0] reqAddr;
  logic [15:0]   reqData;
  logic          doneValid, doneErr;
  logic          flashCeN, flashWeN, flashOeN, flashDoe;
  logic [AW-1:0] flashAddr;
  logic [15:0]   flashDout;
  logic [15:0]   flashDin;

  int total = 0;
  int bad = 0;

  flash_pe_ctrl #(
    .ADDR_W(AW), .DATA_W(16), .SETUP_CYC(1), .PULSE_CYC(PUL), .HOLD_CYC(1),
    .READ_CYC(2), .CONFIRM_RD(2), .CLK_MHZ(1),
    .PROG_TMO_US(PT), .ERASE_TMO_US(ET), .CHIP_TMO_US(CT)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .doneValid(doneValid), .doneErr(doneErr),
    .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN),
    .flashAddr(flashAddr), .flashDout(flashDout), .flashDoe(flashDoe),
    .flashDin(flashDin)
  );

  always #2 clk = ~clk;

  // ---------------- flash model ----------------
  logic          seqV [0:255];
  int            seqLen = 1;
  int            rdCnt = 0, badAddr = 0, wrCnt = 0, weBad = 0;
  logic [AW-1:0] wrA [0:15];
  logic [15:0]   wrD [0:15];
  logic [AW-1:0] curTgt = '0;
  logic [AW-1:0] weFallA;
  time           weFallT;

  function automatic logic seqAt(input int i);
    return seqV[(i < seqLen) ? i : seqLen - 1];
  endfunction

  always @(negedge flashOeN) begin
    if (flashAddr != curTgt) badAddr++;
    flashDin <= {9'h0, seqAt(rdCnt), 6'h0};
    rdCnt++;
  end

  always @(negedge flashWeN) begin
    weFallT = $time;
    weFallA = flashAddr;
  end

  always @(posedge flashWeN) begin
    if (flashCeN === 1'b0) begin
      if (($time - weFallT) != PUL * 4) weBad++;
      if (flashAddr != weFallA || flashDoe !== 1'b1) weBad++;
      if (wrCnt < 16) begin
        wrA[wrCnt] = flashAddr;
        wrD[wrCnt] = flashDout;
      end
      wrCnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic setToggle(input int busy, input logic steady);
    for (int i = 0; i < busy; i++) seqV[i] = ((i % 2) == 0);
    seqV[busy] = steady;
    seqLen = busy + 1;
  endtask

  function automatic int expN();
    for (int n = 4; n < 256; n++)
      if (seqAt(n-1) == seqAt(n-2) && seqAt(n-2) == seqAt(n-3) && seqAt(n-3) == seqAt(n-4))
        return n;
    return 100000;
  endfunction

  task automatic chkWr(input int i, input logic [AW-1:0] a, input logic [15:0] d, input string tag);
    chk($sformatf("%s write %0d addr", tag, i), wrA[i], a);
    chk($sformatf("%s write %0d data", tag, i), wrD[i], d);
  endtask

  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] addr, input logic [15:0] data,
                       input bit inject, input string tag);
    int k, nD, nT, n, expL, lat, tmo, viol;
    bit tmoExp;
    tmo    = (op == 2'd0) ? PT : (op == 2'd3) ? CT : ET;
    k      = (op == 2'd0) ? 4 : 6;
    nD     = expN();
    nT     = (tmo + RSPAN) / RSPAN;
    tmoExp = (nD > nT);
    n      = tmoExp ? nT : nD;
    expL   = k * WSPAN + n * RSPAN + (tmoExp ? WSPAN : 0);
    rdCnt = 0; badAddr = 0; wrCnt = 0; weBad = 0; viol = 0; curTgt = addr;
    @(negedge clk);
    chk({tag, " R10 ready when idle"}, reqReady, 1);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (doneValid) break;
      if (reqReady) viol++;
      if (inject && lat == 3) begin reqValid = 1'b1; reqOp = 2'd3; end
      if (inject && lat == 4) reqValid = 1'b0;
      if (lat > 5000) begin
        chk({tag, " R7 watchdog, no done"}, lat, expL);
        break;
      end
    end
    chk({tag, " R7 done latency"}, lat, expL);
    chk({tag, tmoExp ? " R9 error flag" : " R6 error flag"}, doneErr, tmoExp);
    chk({tag, " R6 status read count"}, rdCnt, n);
    chk({tag, " R5 read address"}, badAddr, 0);
    chk({tag, " R4 write pulse shape"}, weBad, 0);
    chk({tag, " R10 not ready while busy"}, viol, 0);
    chk({tag, tmoExp ? " R9 write count" : " R3 write count"}, wrCnt, k + (tmoExp ? 1 : 0));
    if (tmoExp) chkWr(k, '0, 16'h00F0, {tag, " R9"});
    @(negedge clk);
    chk({tag, " R11 done single pulse"}, doneValid, 0);
    chk({tag, " R10 ready after done"}, reqReady, 1);
  endtask

  task automatic chkPrologue(input logic [15:0] third, input string tag);
    chkWr(0, 22'h555, 16'h00AA, tag);
    chkWr(1, 22'h2AA, 16'h0055, tag);
    chkWr(2, 22'h555, third, tag);
  endtask

  task automatic chkEraseTail(input logic [AW-1:0] a, input logic [15:0] d, input string tag);
    chkPrologue(16'h0080, tag);
    chkWr(3, 22'h555, 16'h00AA, tag);
    chkWr(4, 22'h2AA, 16'h0055, tag);
    chkWr(5, a, d, tag);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqAddr = '0; reqData = '0; flashDin = '0;
    repeat (3) @(negedge clk);
    chk("R1 ce idle", flashCeN, 1);
    chk("R1 we idle", flashWeN, 1);
    chk("R1 oe idle", flashOeN, 1);
    chk("R1 bus released", flashDoe, 0);
    chk("R1 done low", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", reqReady, 1);
  endtask

  task automatic t_program();
    setToggle(5, 1'b0);
    runOp(2'd0, 22'h12345, 16'h1234, 1'b1, "prog");
    chkPrologue(16'h00A0, "R2 prog");
    chkWr(3, 22'h12345, 16'h1234, "R2 prog");
  endtask

  task automatic t_sector();
    setToggle(7, 1'b1);
    runOp(2'd1, 22'h2A800, 16'h0, 1'b0, "sector");
    chkEraseTail(22'h2A800, 16'h0050, "R3 sector");
  endtask

  task automatic t_block();
    setToggle(0, 1'b1);
    runOp(2'd2, 22'h3F8000, 16'h0, 1'b0, "block");
    chkEraseTail(22'h3F8000, 16'h0030, "R3 block");
  endtask

  task automatic t_chip_long();
    setToggle(50, 1'b1);
    runOp(2'd3, 22'h000100, 16'h0, 1'b0, "chip R8 long limit");
    chkEraseTail(22'h555, 16'h0010, "R3 chip");
  endtask

  task automatic t_stall();
    logic pat [0:10] = '{1,0,1,1,0,1,1,1,0,1,0};
    for (int i = 0; i < 11; i++) seqV[i] = pat[i];
    seqV[11] = 1'b1;
    seqLen = 12;
    chk("R6 stall expected reads", expN(), 15);
    runOp(2'd0, 22'h00042, 16'hBEEF, 1'b0, "R6 stall");
  endtask

  task automatic t_prog_timeout();
    setToggle(255, 1'b1);
    runOp(2'd0, 22'h00777, 16'h5A5A, 1'b0, "R8 prog timeout");
    chkPrologue(16'h00A0, "R9 prog timeout");
  endtask

  task automatic t_sector_timeout();
    setToggle(50, 1'b1);
    runOp(2'd1, 22'h001000, 16'h0, 1'b0, "R8 sector timeout");
  endtask

  initial begin
    t_reset();
    t_program();
    t_sector();
    t_block();
    t_chip_long();
    t_stall();
    t_prog_timeout();
    t_sector_timeout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule